// File: doc/BRIEF.md
# Converter Output Latch With Blanking Overrides

This block is the digital back end of a pipelined converter channel. Each clock it accepts one 10-bit conversion result together with a blanking control. It carries both down a fixed delay line that matches the converter's 5.5-clock latency and presents the result on a registered parallel output. The half-clock part of the latency is a capture stage on the falling edge. Five full-cycle stages and the output register follow it on the rising edge.

Two controls can replace the data. The blanking input is active low. It travels down the delay line beside the data, so the near-black code appears on exactly the samples that were taken while blanking was asserted. The power-down input acts on the output at once, with no delay, and forces all zeros. Power-down outranks blanking, and it leaves the contents of the pipeline untouched. A valid flag travels with the data. It reports when the pipeline has filled after reset.

Top module: `adc_out_latch`

## Requirements
- R1: While `rst` is high, and after its release until the first captured word arrives, `data_out` is 0 and `data_valid` is 0.
- R2: A word captured while `blank_n` is low leaves the block as the code 32, which is negative full scale plus 32 LSB in straight binary, with the same latency as data.
- R3: A word captured while `blank_n` is high appears on `data_out` unchanged.
- R4: While `pwr_down` is high, `data_out` is all zeros, and this takes effect in the same cycle, without waiting for a clock edge. `data_valid` is not affected.
- R5: When `pwr_down` is high, it overrides blanking, so the output is 0 and not 32.
- R6: The inputs are captured at a falling edge. The result appears on `data_out` just after the sixth rising edge that follows, which is 5.5 cycles later.
- R7: `data_valid` rises together with the first word captured after reset and then stays high until the next reset.
- R8: Power-down does not disturb the pipeline. Once `pwr_down` falls, the output shows the words captured during power-down at their normal latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock; falling edge captures, rising edge shifts |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 10 | Conversion result from the converter core |
| blank_n | input | 1 | Low: replace this sample with the near-black code |
| pwr_down | input | 1 | High: force the output to zero immediately |
| data_out | output | 10 | Registered output word |
| data_valid | output | 1 | High once the pipeline carries captured words |

## Verification
The bench drives directed words first: all zeros, all ones, the value 32 and a ramp. These show the exact cycle of arrival, and they also show whether a pass-through value of 32 can be told apart from a real blanking substitution. Random words with sparse single-cycle blanking show whether the blanking flag stays aligned with its own sample, as opposed to being applied to a neighbour at the wrong depth. Random power-down windows that overlap blanking show three things: the priority between the two codes, the immediate effect, checked between clock edges, and whether the pipeline survives once power-down is released. A second reset in mid-stream checks that the valid flag refills.

// File: rtl/adc_out_latch_pkg.sv
`timescale 1ns/1ps
package adc_out_latch_pkg;

    localparam int unsigned WORD_W = 10;

    typedef logic [WORD_W-1:0] word_t;

    // One pipeline slot: flags ride beside the sample they qualify.
    typedef struct packed {
        logic  valid;
        logic  blank;
        word_t code;
    } lane_t;

    function automatic lane_t lane_capture(input word_t smp, input logic blank_n);
        lane_t l;
        l.valid = 1'b1;
        l.blank = ~blank_n;
        l.code  = smp;
        return l;
    endfunction

    function automatic word_t shape_code(input lane_t l, input word_t level);
        return l.blank ? level : l.code;
    endfunction

endpackage

// File: rtl/aol_half_stage.sv
`timescale 1ns/1ps
module aol_half_stage
    import adc_out_latch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t sample_in,
    input  logic  blank_n,
    output lane_t q
);

    // Half-cycle part of the latency: capture on the falling edge.
    always_ff @(negedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= lane_capture(sample_in, blank_n);
        end
    end

endmodule

// File: rtl/aol_delay_line.sv
`timescale 1ns/1ps
module aol_delay_line
    import adc_out_latch_pkg::*;
#(
    parameter int unsigned DEPTH = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t d_in,
    output lane_t q
);

    lane_t stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[DEPTH-1];

    // R7: the line fills from its head, so a valid tail implies a valid neighbour.
    if (DEPTH >= 2) begin : g_fill_chk
        assert_fill_order_R7: assert property (@(posedge clk) disable iff (rst)
            stg[DEPTH-1].valid |-> stg[DEPTH-2].valid)
            else $error("fill order broken");
    end

endmodule

// File: rtl/aol_out_stage.sv
`timescale 1ns/1ps
module aol_out_stage
    import adc_out_latch_pkg::*;
#(
    parameter word_t LEVEL = word_t'(32)
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane_in,
    input  logic  pwr_down,
    output word_t data_out,
    output logic  data_valid
);

    word_t code_q;
    logic  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            code_q  <= shape_code(lane_in, LEVEL);
            valid_q <= lane_in.valid;
        end
    end

    // Power-down bypasses the register so it acts without delay.
    assign data_out   = pwr_down ? '0 : code_q;
    assign data_valid = valid_q;

    assert_blank_code_R2: assert property (@(posedge clk) disable iff (rst)
        lane_in.blank |=> (pwr_down || data_out == LEVEL))
        else $error("blank code wrong");

    assert_pass_data_R3: assert property (@(posedge clk) disable iff (rst)
        (lane_in.valid && !lane_in.blank) |=> (pwr_down || data_out == $past(lane_in.code)))
        else $error("pass-through data wrong");

    assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> data_valid)
        else $error("valid dropped");

endmodule

// File: rtl/adc_out_latch.sv
`timescale 1ns/1ps
module adc_out_latch
    import adc_out_latch_pkg::*;
#(
    parameter int unsigned FULL_STAGES = 5,
    parameter int unsigned BLANK_LEVEL = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] sample_in,
    input  logic              blank_n,
    input  logic              pwr_down,
    output logic [WORD_W-1:0] data_out,
    output logic              data_valid
);

    localparam word_t LEVEL = BLANK_LEVEL[WORD_W-1:0];

    lane_t half_q;
    lane_t tail_q;

    aol_half_stage u_half (
        .clk       (clk),
        .rst       (rst),
        .sample_in (sample_in),
        .blank_n   (blank_n),
        .q         (half_q)
    );

    aol_delay_line #(.DEPTH(FULL_STAGES)) u_line (
        .clk  (clk),
        .rst  (rst),
        .d_in (half_q),
        .q    (tail_q)
    );

    aol_out_stage #(.LEVEL(LEVEL)) u_out (
        .clk        (clk),
        .rst        (rst),
        .lane_in    (tail_q),
        .pwr_down   (pwr_down),
        .data_out   (data_out),
        .data_valid (data_valid)
    );

endmodule

// File: tb/adc_out_latch_test.sv
`timescale 1ns/1ps
module adc_out_latch_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] sample_in = '0;
    logic       blank_n = 1'b1;
    logic       pwr_down = 1'b0;
    logic [9:0] data_out;
    logic       data_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int  rel = 0;
    bit  in_reset = 1;
    int  hist_d [8];
    bit  hist_b [8];
    bit  hist_p [8];
    logic [9:0] held = '0;

    always #4 clk = ~clk;

    adc_out_latch uut (
        .clk(clk), .rst(rst), .sample_in(sample_in), .blank_n(blank_n),
        .pwr_down(pwr_down), .data_out(data_out), .data_valid(data_valid)
    );

    function automatic logic [9:0] expect_word(input int d, input bit bn, input bit pd);
        if (pd) return 10'd0;
        if (!bn) return 10'd32;
        return d[9:0];
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // One clock: check output just after the rising edge, then drive the next inputs.
    task automatic cycle(input int d, input bit bn, input bit pd);
        int  n;
        bit  ev;
        string tag;
        @(posedge clk);
        #1;
        n = rel - 6;
        if (in_reset || n < 0) begin
            ev = 0;
            held = '0;
            tag = "R1";
        end else begin
            ev = 1;
            held = expect_word(hist_d[n % 8], hist_b[n % 8], 1'b0);
            if (pwr_down && !hist_b[n % 8]) tag = "R5";
            else if (pwr_down)               tag = "R4";
            else if (hist_p[n % 8])          tag = "R8";
            else if (!hist_b[n % 8])         tag = "R2";
            else                             tag = "R3 R6";
        end
        check(tag, int'(data_out), int'(pwr_down ? 10'd0 : held));
        check(in_reset ? "R1" : "R7", int'(data_valid), int'(ev));
        #1;
        sample_in = d[9:0];
        blank_n   = bn;
        pwr_down  = pd;
        if (!in_reset) begin
            hist_d[rel % 8] = d;
            hist_b[rel % 8] = bn;
            hist_p[rel % 8] = pd;
            rel++;
        end
        #1;
        // R4: power-down acts between edges, and its release does too.
        check("R4", int'(data_out), int'(pd ? 10'd0 : held));
    endtask

    task automatic do_reset(input int cycles);
        @(posedge clk);
        #2 rst = 1'b1;
        in_reset = 1;
        pwr_down = 1'b0;
        for (int i = 0; i < cycles; i++) cycle(0, 1'b1, 1'b0);
        @(posedge clk);
        #1;
        check("R1", int'(data_out), 0);
        check("R1", int'(data_valid), 0);
        #1;
        rst = 1'b0;
        in_reset = 0;
        rel = 0;
        sample_in = 10'd0;
        blank_n = 1'b1;
        hist_d[0] = 0;
        hist_b[0] = 1;
        hist_p[0] = 0;
        rel = 1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset(4);
        // R6 R3: directed extremes and a value equal to the blank code
        cycle(1023, 1, 0);
        cycle(32, 1, 0);
        cycle(1, 1, 0);
        for (int i = 0; i < 10; i++) cycle(100 + i * 7, 1, 0);
        // R2: a single blanked sample among full-scale words
        cycle(1023, 1, 0);
        cycle(1023, 0, 0);
        cycle(1023, 1, 0);
        for (int i = 0; i < 8; i++) cycle(500, 1, 0);
        // R3 random pass-through
        for (int i = 0; i < 60; i++) cycle(int'($urandom_range(0, 1023)), 1, 0);
        // R2 random sparse blanking
        for (int i = 0; i < 200; i++)
            cycle(int'($urandom_range(0, 1023)), ($urandom_range(0, 3) != 0), 0);
        // R4 R5 R8: power-down windows over blanking traffic
        for (int i = 0; i < 20; i++) begin
            int len = int'($urandom_range(1, 8));
            for (int j = 0; j < len; j++)
                cycle(int'($urandom_range(0, 1023)), ($urandom_range(0, 2) != 0), 1);
            for (int j = 0; j < 8; j++)
                cycle(int'($urandom_range(0, 1023)), ($urandom_range(0, 2) != 0), 0);
        end
        // R1 R7: reset in mid-stream, then refill
        do_reset(3);
        for (int i = 0; i < 30; i++)
            cycle(int'($urandom_range(0, 1023)), ($urandom_range(0, 3) != 0), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule